// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Port

This block is an 8-bit full-duplex synchronous shift port for a controller whose internal data bus is four bits wide. Software places a byte into the shift register as two nibbles, sets the start bit, and reads the received byte back as two nibbles once the transfer is over. On each active edge of the shift clock the port drives one bit out and captures one bit in. After eight active edges the byte is complete and the port raises a one-cycle interrupt.

The port runs in one of two clock modes. In master mode it takes the shift clock from one of three prescaler taps and drives that clock onto the clock pin. In slave mode it takes the shift clock from that pin through a synchronizer. Software also chooses the active edge, the bit order, and a direct-output option that keeps the head bit on the data-out pin while the port is idle. One pin is shared: it carries an active-low select in master mode and a ready flag in slave mode. When the port is disabled, none of the four pins is driven.

Register map on `cpu_addr`:
- 0, MODE: bit0 enable, bit1 master, bits 3:2 tap select.
- 1, CTRL: bit0 falling edge, bit1 LSB first, bit2 direct, bit3 start on write and busy on read.
- 2, DLO: shift register bits 3:0.
- 3, DHI: shift register bits 7:4.

Top module: `shift_port`

## Requirements
- R1: After reset the shift register, MODE and CTRL read 0, no transfer is busy, `irq` is 0 and `pin_oe` is 0000.
- R2: Pin roles are fixed: pin 0 is data in, pin 1 is the select line, pin 2 is data out and pin 3 is the clock. With enable 0, `pin_oe` is 0000. In enabled master mode it is 1110; in enabled slave mode it is 0110.
- R3: When idle, a write to DLO or DHI loads bits 3:0 or 7:4 of the shift register, and a read of the same address returns that nibble.
- R4: Writing CTRL with bit3 set while enabled and idle starts a transfer. CTRL bit3 reads 1 until the 8th shift. `irq` pulses high for exactly the one cycle in which busy clears.
- R5: Each shift sends the head bit on pin 2 and captures pin 0 into the register. After 8 shifts the transmitted byte has gone out in full and DLO/DHI hold the received byte.
- R6: With CTRL bit1 at 0 the order is MSB first (head is bit 7, new bits enter at bit 0). With bit1 at 1 it is LSB first (head is bit 0, new bits enter at bit 7).
- R7: CTRL bit0 selects the active edge: 0 for rising, 1 for falling. In master mode the clock pin idles at the inactive level, which equals bit0.
- R8: In master mode, tap select values 0, 1 and 2 pick `pre_taps` bit 0, 1 or 2; value 3 acts as 2. The clock pin toggles with the selected tap while busy. The bit is shifted one cycle after the active clock edge appears on the pin.
- R9: In slave mode the shift clock comes from `pin_in[3]` through a two-flop synchronizer, and pin 3 is not driven.
- R10: Pin 1 outputs 0 while a master transfer is busy and 1 otherwise. In slave mode it outputs 1 while busy (ready) and 0 otherwise.
- R11: With direct set, pin 2 shows the head bit at all times. With direct clear, pin 2 shows the head bit only while busy and is 1 when idle.
- R12: While busy, writes to MODE, CTRL (including a repeated start), DLO and DHI have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 4 | Write nibble |
| cpu_rdata | output | 4 | Read nibble (combinational) |
| pre_taps | input | N_TAPS | Prescaler tap levels, fastest at bit 0 |
| pin_in | input | 4 | Pin levels seen from the pads |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |
| irq | output | 1 | Byte-complete pulse |

## Verification
The assertions assume three things about the inputs. Each prescaler tap and the external clock stay at one level for several system cycles. Data in changes only well away from the active edge that samples it. Software issues no register access other than the ones the map describes. The stimulus meets these conditions: tap half-periods are at least four cycles, the slave clock holds each level for four cycles, and data in changes only on the inactive clock edge after a bit has been sampled. Edge choice, bit order, tap choice and direct mode are varied across transfers. Writes issued in the middle of a transfer are checked to have no effect.

// File: rtl/shport_pkg.sv
package shport_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int N_NIB  = BYTE_W / NIB_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        A_MODE = 2'd0,
        A_CTRL = 2'd1,
        A_DLO  = 2'd2,
        A_DHI  = 2'd3
    } addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] tap;
        logic             master;
        logic             en;
    } mode_t;

    typedef struct packed {
        logic start;
        logic direct;
        logic lsb;
        logic fall;
    } ctrl_t;

    function automatic logic [SEL_W-1:0] clip_sel(logic [SEL_W-1:0] s, int n);
        return (int'(s) >= n) ? SEL_W'(n - 1) : s;
    endfunction

endpackage

// File: rtl/shport_clkgen.sv
module shport_clkgen
    import shport_pkg::*;
#(
    parameter int N_TAPS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              master,
    input  logic              fall,
    input  logic              busy,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              shift_go
);

    logic [SEL_W-1:0] sel_eff;
    logic             tap_now;
    logic             tap_q1, tap_q2;
    logic             s_meta, s_sync, s_prev;
    logic             m_rise, m_fall, m_act;
    logic             s_act;
    logic             pend;

    assign sel_eff = clip_sel(tap_sel, N_TAPS);

    always_comb begin
        tap_now = 1'b0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (sel_eff == SEL_W'(i)) tap_now = taps[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q1 <= 1'b0;
            tap_q2 <= 1'b0;
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            tap_q1 <= tap_now;
            tap_q2 <= tap_q1;
            s_meta <= sclk_in;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign m_rise = tap_q1 & ~tap_q2;
    assign m_fall = ~tap_q1 & tap_q2;
    assign m_act  = fall ? m_fall : m_rise;
    assign s_act  = fall ? (~s_sync & s_prev) : (s_sync & ~s_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_out <= 1'b0;
            pend     <= 1'b0;
        end else begin
            pend <= master & busy & m_act;
            if (!busy || !master)  sclk_out <= fall;
            else if (m_rise)       sclk_out <= 1'b1;
            else if (m_fall)       sclk_out <= 1'b0;
        end
    end

    assign shift_go = master ? pend : (s_act & busy);

    AST_PEND_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        pend |-> (sclk_out == ~fall)) else $error("pend without active level"); // R8

endmodule

// File: rtl/shport_engine.sv
module shport_engine
    import shport_pkg::*;
#(
    parameter int W   = BYTE_W,
    parameter int NIB = NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W/NIB-1:0]   load_nib,
    input  logic [NIB-1:0]     wdata,
    input  logic               start,
    input  logic               lsb,
    input  logic               sin,
    input  logic               shift_go,
    output logic [W-1:0]       shreg,
    output logic               busy,
    output logic               irq,
    output logic               head
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  loaded;

    generate
        for (genvar g = 0; g < W / NIB; g++) begin : g_nib
            assign loaded[g*NIB +: NIB] = load_nib[g] ? wdata : shreg[g*NIB +: NIB];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            busy  <= 1'b0;
            irq   <= 1'b0;
            cnt   <= '0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy && shift_go) begin
                shreg <= lsb ? {sin, shreg[W-1:1]} : {shreg[W-2:0], sin};
                cnt   <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    irq  <= 1'b1;
                end
            end else if (!busy) begin
                shreg <= loaded;
            end
        end
    end

    assign head = lsb ? shreg[0] : shreg[W-1];

    AST_SHIFT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        shift_go |-> busy) else $error("shift while idle"); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq wider than one cycle"); // R4
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy) else $error("irq while busy"); // R4
    AST_START_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt == '0)) else $error("count not cleared"); // R4

endmodule

// File: rtl/shift_port.sv
module shift_port
    import shport_pkg::*;
#(
    parameter int N_TAPS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic [3:0]        cpu_wdata,
    output logic [3:0]        cpu_rdata,
    input  logic [N_TAPS-1:0] pre_taps,
    input  logic [3:0]        pin_in,
    output logic [3:0]        pin_out,
    output logic [3:0]        pin_oe,
    output logic              irq
);

    mode_t              mode_q;
    ctrl_t              ctrl_q;
    ctrl_t              ctrl_w;
    addr_e              addr;
    logic               busy;
    logic               head;
    logic               sclk_out;
    logic               shift_go;
    logic               start_req;
    logic               sout;
    logic               sel_line;
    logic [N_NIB-1:0]   load_nib;
    logic [BYTE_W-1:0]  shreg;
    logic               unused_pins;

    assign addr        = addr_e'(cpu_addr);
    assign ctrl_w      = ctrl_t'(cpu_wdata);
    assign unused_pins = ^pin_in[2:1];
    assign start_req   = cpu_wr && (addr == A_CTRL) && ctrl_w.start && mode_q.en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctrl_q <= '0;
        end else if (cpu_wr && !busy) begin
            if (addr == A_MODE) mode_q <= mode_t'(cpu_wdata);
            if (addr == A_CTRL) ctrl_q <= '{start: 1'b0, direct: ctrl_w.direct,
                                            lsb: ctrl_w.lsb, fall: ctrl_w.fall};
        end
    end

    assign load_nib[0] = cpu_wr && !busy && (addr == A_DLO);
    assign load_nib[1] = cpu_wr && !busy && (addr == A_DHI);

    shport_clkgen #(.N_TAPS(N_TAPS)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .taps     (pre_taps),
        .tap_sel  (mode_q.tap),
        .master   (mode_q.master),
        .fall     (ctrl_q.fall),
        .busy     (busy),
        .sclk_in  (pin_in[3]),
        .sclk_out (sclk_out),
        .shift_go (shift_go)
    );

    shport_engine #(.W(BYTE_W), .NIB(NIB_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .load_nib (load_nib),
        .wdata    (cpu_wdata),
        .start    (start_req),
        .lsb      (ctrl_q.lsb),
        .sin      (pin_in[0]),
        .shift_go (shift_go),
        .shreg    (shreg),
        .busy     (busy),
        .irq      (irq),
        .head     (head)
    );

    always_comb begin
        case (addr)
            A_MODE:  cpu_rdata = mode_q;
            A_CTRL:  cpu_rdata = {busy, ctrl_q.direct, ctrl_q.lsb, ctrl_q.fall};
            A_DLO:   cpu_rdata = shreg[NIB_W-1:0];
            default: cpu_rdata = shreg[BYTE_W-1:NIB_W];
        endcase
    end

    assign sout     = (ctrl_q.direct || busy) ? head : 1'b1;
    assign sel_line = mode_q.master ? ~busy : busy;
    assign pin_out  = {mode_q.master & sclk_out, sout, sel_line, 1'b0};
    assign pin_oe   = mode_q.en ? {mode_q.master, 1'b1, 1'b1, 1'b0} : 4'b0000;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(ctrl_q))) else $error("config changed while busy"); // R12
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mode_q.en) else $error("transfer while disabled"); // R4

endmodule

// File: tb/tb_shift_port.sv
module tb_shift_port;

    localparam int N_TAPS = 3;

    typedef struct {
        logic [7:0] tx;
        int         period;
        bit         master;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cpu_addr = '0;
    logic              cpu_wr = 1'b0;
    logic [3:0]        cpu_wdata = '0;
    logic [3:0]        cpu_rdata;
    logic [N_TAPS-1:0] pre_taps;
    logic [3:0]        pin_in;
    logic [3:0]        pin_out;
    logic [3:0]        pin_oe;
    logic              irq;

    logic [7:0] presc = '0;
    logic       sclk_tb = 1'b0;
    logic       sin_tb = 1'b0;

    bit         cur_master, cur_fall, cur_lsb;
    logic [7:0] cur_rx;
    bit         xfer_on = 0;
    int         n_col = 0;
    logic [7:0] tx_col = '0;
    logic       prev_obs = 1'b0;
    longint     cyc = 0;
    longint     last_act = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    item_t      sb_q[$];

    assign pre_taps = presc[4:2];
    assign pin_in   = {sclk_tb, 2'b00, sin_tb};

    shift_port #(.N_TAPS(N_TAPS)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pre_taps(pre_taps),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        presc = presc + 1'b1;
        cyc   = cyc + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic bit_of(input logic [7:0] p, input int i, input bit lsbf);
        return lsbf ? p[i] : p[7-i];
    endfunction

    task automatic cpu_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    // monitor: collects sent bits, feeds data-in, pops the scoreboard on irq
    initial forever begin
        logic obs, act, inact;
        @(negedge clk);
        #2;
        obs   = cur_master ? pin_out[3] : sclk_tb;
        act   = cur_fall ? (prev_obs & ~obs) : (~prev_obs & obs);
        inact = cur_fall ? (~prev_obs & obs) : (prev_obs & ~obs);
        if (xfer_on && act) begin
            tx_col = cur_lsb ? {pin_out[2], tx_col[7:1]} : {tx_col[6:0], pin_out[2]};
            n_col++;
            if (n_col == 1) begin
                check(pin_out[1] == (cur_master ? 1'b0 : 1'b1), "R10 select while busy", pin_out[1], !cur_master);
                if (!cur_master) check(pin_oe[3] == 1'b0, "R9 clock pin not driven", pin_oe[3], 0);
            end
            if (cur_master && n_col == 2 && sb_q.size() > 0)
                check(int'(cyc - last_act) == sb_q[0].period, "R8 master clock period", cyc - last_act, sb_q[0].period);
            last_act = cyc;
        end
        if (xfer_on && inact && n_col > 0 && n_col < 8)
            sin_tb = bit_of(cur_rx, n_col, cur_lsb);
        if (xfer_on && irq) begin
            if (sb_q.size() == 0) begin
                check(0, "R4 unexpected completion", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(tx_col == it.tx, "R5 R6 sent byte", tx_col, it.tx);
                check(n_col == 8, "R4 eight shifts", n_col, 8);
                check(pin_out[1] == (it.master ? 1'b1 : 1'b0), "R10 select after done", pin_out[1], it.master);
            end
            xfer_on = 0;
        end
        prev_obs = obs;
    end

    task automatic run_xfer(input bit master, input logic [1:0] tap, input bit fall, input bit lsbf,
                            input bit direct, input logic [7:0] tx, input logic [7:0] rx, input bit poke);
        logic [3:0] lo, hi, c;
        item_t it;
        cpu_write(2'd0, {tap, master, 1'b1});
        cpu_write(2'd1, {1'b0, direct, lsbf, fall});
        cpu_write(2'd2, tx[3:0]);
        cpu_write(2'd3, tx[7:4]);
        cur_master = master; cur_fall = fall; cur_lsb = lsbf; cur_rx = rx;
        sclk_tb = fall;
        sin_tb  = bit_of(rx, 0, lsbf);
        repeat (4) @(negedge clk);
        if (master) check(pin_out[3] == fall, "R7 idle clock level", pin_out[3], fall);
        check(pin_out[2] == (direct ? (lsbf ? tx[0] : tx[7]) : 1'b1), "R11 idle data-out", pin_out[2],
              direct ? (lsbf ? tx[0] : tx[7]) : 1'b1);
        it.tx = tx; it.period = 8 << ((tap == 2'd3) ? 2 : tap); it.master = master;
        sb_q.push_back(it);
        n_col = 0; tx_col = '0;
        prev_obs = master ? pin_out[3] : sclk_tb;
        xfer_on = 1;
        cpu_write(2'd1, {1'b1, direct, lsbf, fall});
        cpu_read(2'd1, c);
        check(c[3] == 1'b1, "R4 busy after start", c[3], 1);
        if (poke) begin
            cpu_write(2'd2, 4'hF);
            cpu_write(2'd0, 4'h0);
            cpu_write(2'd1, {1'b1, ~direct, ~lsbf, ~fall});
        end
        if (!master) begin
            for (int b = 0; b < 8; b++) begin
                repeat (4) @(negedge clk);
                sclk_tb = ~fall;
                repeat (4) @(negedge clk);
                sclk_tb = fall;
            end
        end
        while (xfer_on) @(negedge clk);
        repeat (2) @(negedge clk);
        cpu_read(2'd2, lo);
        cpu_read(2'd3, hi);
        check({hi, lo} == rx, "R5 R6 received byte", {hi, lo}, rx);
        cpu_read(2'd1, c);
        check(c == {1'b0, direct, lsbf, fall}, "R12 R4 ctrl after transfer", c, {1'b0, direct, lsbf, fall});
        if (poke) check(pin_oe == 4'b0110, "R12 mode write ignored", pin_oe, 4'b0110);
    endtask

    initial begin
        logic [3:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pin_oe == 4'b0000, "R1 pins released", pin_oe, 0);
        check(irq == 1'b0, "R1 irq low", irq, 0);
        for (int a = 0; a < 4; a++) begin
            cpu_read(a[1:0], v);
            check(v == 4'h0, "R1 register reset", v, 0);
        end
        cpu_write(2'd0, 4'b0011);
        check(pin_oe == 4'b1110, "R2 master pin roles", pin_oe, 4'b1110);
        cpu_write(2'd0, 4'b0001);
        check(pin_oe == 4'b0110, "R2 slave pin roles", pin_oe, 4'b0110);
        cpu_write(2'd0, 4'b0010);
        check(pin_oe == 4'b0000, "R2 disabled pins", pin_oe, 0);
        cpu_write(2'd1, 4'b1000);
        cpu_read(2'd1, v);
        check(v[3] == 1'b0, "R4 no start while disabled", v[3], 0);
        cpu_write(2'd2, 4'h5);
        cpu_write(2'd3, 4'hA);
        cpu_read(2'd2, v);
        check(v == 4'h5, "R3 low nibble", v, 5);
        cpu_read(2'd3, v);
        check(v == 4'hA, "R3 high nibble", v, 4'hA);

        run_xfer(1, 2'd0, 0, 0, 0, 8'hA5, 8'h3C, 0);
        run_xfer(1, 2'd1, 1, 1, 1, 8'h81, 8'hE7, 0);
        run_xfer(1, 2'd3, 0, 1, 0, 8'h0F, 8'hF0, 0);
        run_xfer(0, 2'd0, 0, 0, 0, 8'h5A, 8'hC3, 1);
        run_xfer(0, 2'd0, 1, 1, 1, 8'h96, 8'h69, 0);

        check(sb_q.size() == 0, "R4 all transfers completed", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule